// File: doc/BRIEF.md
# Store-Coalescing Write Buffer

This block gathers a run of byte-addressed stores that follow one another in memory into a single entry of up to `NBYTES` bytes. The entry is then sent to memory as one write. Every store brings an address, a data word, a byte count, a 3-bit access-type tag and an exclusive flag. The first store into an empty buffer sets the entry's base address, tag and flag. Each later store must carry the same tag and flag and must start at the first byte after the bytes already held. Its bytes are then placed above those bytes.

A flush command sends the entry out on a valid/ready write port. The write carries a 2-bit kind code, which is chosen from the access tag and from the path the flush asks for: plain or exclusive. A write on the exclusive path returns a success bit from memory, and the block reports that bit once the handshake completes. Any rule that is broken raises a sticky error flag and leaves the buffer as it was. Reset is the only way to clear that flag.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the write port is idle (`mem_valid`=0), `err`=0, `excl_done`=0 and the buffer holds no bytes.
- R2: A store into the empty buffer loads its address, tag, flag and byte count. Only the low `st_bytes` bytes of `st_data` are kept, and the bytes above them read as zero in any later write.
- R3: A legal store into a non-empty buffer that holds `n` bytes places its bytes at byte lanes `n` and up. The existing low `n` bytes are kept, and the byte count grows by `st_bytes`.
- R4: A store whose access tag or exclusive flag differs from the buffer's sets `err` and does not change the buffer.
- R5: A store into a non-empty buffer whose address is not the base address plus the held byte count sets `err` and does not change the buffer.
- R6: A store with a byte count of zero, or one that would make the total exceed `NBYTES`, sets `err` and does not change the buffer.
- R7: A flush is accepted only when the buffer holds 1, 2, 4, 8 or 16 bytes. Any other count, including zero, sets `err`, issues no write and keeps the buffer.
- R8: A plain flush (`flush_excl`=0) needs the flag to be clear. Tags 0 (normal), 1 (streaming) and 2 (unprivileged) issue kind 0 (normal write), and tag 3 (ordered) issues kind 1 (ordered write). Any other tag, or a set flag, sets `err` and issues no write.
- R9: An exclusive flush (`flush_excl`=1) needs the flag to be set. Tag 4 (atomic) issues kind 2 (atomic write), and tag 3 issues kind 3 (atomic-ordered write). Any other tag, or a clear flag, sets `err`. One cycle after the handshake `excl_done` pulses high for one cycle and `excl_pass` equals the `mem_ok` value seen at the handshake.
- R10: `mem_valid` and the address, size, data and kind fields stay stable until `mem_ready`. After the handshake cycle the buffer is empty and the port is idle.
- R11: Once `err` is set it stays set until reset, including across later legal operations.
- R12: A store or flush that arrives while a write is outstanding, or a store and a flush in the same cycle, sets `err` and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store present this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | NBYTES*8 | Store data, low bytes significant |
| st_bytes | input | CNT_W | Store byte count |
| st_acc | input | 3 | Store access tag |
| st_excl | input | 1 | Store exclusive flag |
| flush_req | input | 1 | Flush command |
| flush_excl | input | 1 | Flush path: 1 exclusive, 0 plain |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write base address |
| mem_bytes | output | CNT_W | Write byte count |
| mem_data | output | NBYTES*8 | Write data, zero above the byte count |
| mem_kind | output | 2 | 0 normal, 1 ordered, 2 atomic, 3 atomic-ordered |
| mem_ok | input | 1 | Exclusive success from memory, sampled at the handshake |
| excl_done | output | 1 | One-cycle pulse after an exclusive write completes |
| excl_pass | output | 1 | Success of the last exclusive write |
| err | output | 1 | Sticky rule-violation flag |

## Verification
The bench builds the block with its defaults: a 64-bit address and `NBYTES`=16, which makes `CNT_W`=5. With a 16-byte entry, every legal flush size from one byte up to a full 128-bit merge of five stores of mixed width can be reached. A 5-bit count can also carry the out-of-range store sizes 0 and 17, and the 24-byte overflow case can be reached as well. Each access tag is taken through both flush paths, and the write port is held back by several not-ready cycles so that the fields can be watched while the write is outstanding.

// File: rtl/smb_pkg.sv
// Shared codes for the store-coalescing write buffer.
// Assumes a 3-bit access tag and a 2-bit write-kind code on the memory side.
package smb_pkg;
    localparam logic [2:0] ACC_NORMAL  = 3'd0;
    localparam logic [2:0] ACC_STREAM  = 3'd1;
    localparam logic [2:0] ACC_UNPRIV  = 3'd2;
    localparam logic [2:0] ACC_ORDERED = 3'd3;
    localparam logic [2:0] ACC_ATOMIC  = 3'd4;

    typedef enum logic [1:0] {
        WK_NORMAL     = 2'd0,
        WK_ORDERED    = 2'd1,
        WK_ATOMIC     = 2'd2,
        WK_ATOMIC_ORD = 2'd3
    } wkind_t;
endpackage

// File: rtl/smb_byte_mask.sv
// Byte-lane mask generator: lane i is all ones when i < cnt.
// Assumes cnt never exceeds NBYTES (higher values simply give all ones).
module smb_byte_mask #(
    parameter int NBYTES = 16,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0]    cnt,
    output logic [NBYTES*8-1:0] mask
);
    // One comparator per byte lane
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign mask[i*8 +: 8] = {8{cnt > CNT_W'(i)}};
    end
endmodule

// File: rtl/smb_merge.sv
// Store merge unit: decides whether an incoming store may join the entry
// and forms the merged data and byte count. Purely combinational.
// Assumes the held data is zero above the held byte count.
module smb_merge #(
    parameter int ADDR_W = 64,
    parameter int NBYTES = 16,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0]    buf_bytes,
    input  logic [ADDR_W-1:0]   buf_addr,
    input  logic [NBYTES*8-1:0] buf_data,
    input  logic [2:0]          buf_acc,
    input  logic                buf_excl,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [NBYTES*8-1:0] st_data,
    input  logic [CNT_W-1:0]    st_bytes,
    input  logic [2:0]          st_acc,
    input  logic                st_excl,
    output logic                ok,
    output logic [NBYTES*8-1:0] next_data,
    output logic [CNT_W-1:0]    next_bytes
);
    localparam logic [CNT_W:0] MAX_SUM = (CNT_W+1)'(NBYTES);

    logic [NBYTES*8-1:0] st_mask;
    logic [NBYTES*8-1:0] clean_in;
    logic [CNT_W:0]      sum;
    logic                empty;
    logic                attr_match;
    logic                contiguous;

    smb_byte_mask #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_st_mask (
        .cnt (st_bytes),
        .mask(st_mask)
    );

    // Rule checks and merged value
    always_comb begin
        empty      = (buf_bytes == '0);
        clean_in   = st_data & st_mask;
        sum        = {1'b0, buf_bytes} + {1'b0, st_bytes};
        attr_match = (st_acc == buf_acc) && (st_excl == buf_excl);
        contiguous = (st_addr == buf_addr + ADDR_W'(buf_bytes));
        ok         = (st_bytes != '0) && (sum <= MAX_SUM) &&
                     (empty || (attr_match && contiguous));
        next_data  = (clean_in << {buf_bytes, 3'b000}) | buf_data;
        next_bytes = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/smb_route.sv
// Flush router: checks the flush size and picks the write kind from the
// access tag and the requested path. Purely combinational.
// Assumes NBYTES is a power of two.
module smb_route #(
    parameter int NBYTES = 16,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0] buf_bytes,
    input  logic [2:0]       buf_acc,
    input  logic             buf_excl,
    input  logic             flush_excl,
    output logic             ok,
    output logic [1:0]       kind
);
    import smb_pkg::*;

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NBYTES);

    logic   size_ok;
    logic   type_ok;
    wkind_t k;

    // Size legality and kind selection
    always_comb begin
        size_ok = (buf_bytes != '0) && (buf_bytes <= MAX_CNT) &&
                  ((buf_bytes & (buf_bytes - 1'b1)) == '0);
        type_ok = 1'b0;
        k       = WK_NORMAL;
        if (flush_excl) begin
            if (buf_acc == ACC_ATOMIC) begin
                type_ok = 1'b1;
                k       = WK_ATOMIC;
            end else if (buf_acc == ACC_ORDERED) begin
                type_ok = 1'b1;
                k       = WK_ATOMIC_ORD;
            end
        end else begin
            if (buf_acc == ACC_NORMAL || buf_acc == ACC_STREAM ||
                buf_acc == ACC_UNPRIV) begin
                type_ok = 1'b1;
                k       = WK_NORMAL;
            end else if (buf_acc == ACC_ORDERED) begin
                type_ok = 1'b1;
                k       = WK_ORDERED;
            end
        end
        ok   = size_ok && type_ok && (buf_excl == flush_excl);
        kind = k;
    end
endmodule

// File: rtl/store_merge_buf.sv
// Store-coalescing write buffer top. Holds one entry, merges contiguous
// stores into it, and issues it on a valid/ready write port when flushed.
// Assumes the memory side returns mem_ok together with mem_ready.
module store_merge_buf #(
    parameter int ADDR_W = 64,
    parameter int NBYTES = 16,
    parameter int CNT_W  = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [NBYTES*8-1:0] st_data,
    input  logic [CNT_W-1:0]    st_bytes,
    input  logic [2:0]          st_acc,
    input  logic                st_excl,
    input  logic                flush_req,
    input  logic                flush_excl,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [CNT_W-1:0]    mem_bytes,
    output logic [NBYTES*8-1:0] mem_data,
    output logic [1:0]          mem_kind,
    input  logic                mem_ok,
    output logic                excl_done,
    output logic                excl_pass,
    output logic                err
);
    localparam int DATA_W = NBYTES * 8;

    logic [CNT_W-1:0]  buf_bytes;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic [2:0]        buf_acc;
    logic              buf_excl;
    logic              pend;
    logic [1:0]        pend_kind;

    logic              merge_ok;
    logic [DATA_W-1:0] merge_data;
    logic [CNT_W-1:0]  merge_bytes;
    logic              route_ok;
    logic [1:0]        route_kind;
    logic              st_fire;
    logic              fl_fire;
    logic              bad;
    logic              hs;

    smb_merge #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_merge (
        .buf_bytes (buf_bytes),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .buf_acc   (buf_acc),
        .buf_excl  (buf_excl),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_bytes  (st_bytes),
        .st_acc    (st_acc),
        .st_excl   (st_excl),
        .ok        (merge_ok),
        .next_data (merge_data),
        .next_bytes(merge_bytes)
    );

    smb_route #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_route (
        .buf_bytes (buf_bytes),
        .buf_acc   (buf_acc),
        .buf_excl  (buf_excl),
        .flush_excl(flush_excl),
        .ok        (route_ok),
        .kind      (route_kind)
    );

    // Decide which command fires and whether a rule is broken
    always_comb begin
        st_fire = st_valid && !flush_req && !pend && merge_ok;
        fl_fire = flush_req && !st_valid && !pend && route_ok;
        hs      = pend && mem_ready;
        bad     = (st_valid || flush_req) && !st_fire && !fl_fire;
    end

    // Entry, pending write and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_bytes <= '0;
            buf_addr  <= '0;
            buf_data  <= '0;
            buf_acc   <= '0;
            buf_excl  <= 1'b0;
            pend      <= 1'b0;
            pend_kind <= '0;
            excl_done <= 1'b0;
            excl_pass <= 1'b0;
            err       <= 1'b0;
        end else begin
            excl_done <= 1'b0;
            if (bad) begin
                err <= 1'b1;
            end
            if (st_fire) begin
                buf_data  <= merge_data;
                buf_bytes <= merge_bytes;
                if (buf_bytes == '0) begin
                    buf_addr <= st_addr;
                    buf_acc  <= st_acc;
                    buf_excl <= st_excl;
                end
            end
            if (fl_fire) begin
                pend      <= 1'b1;
                pend_kind <= route_kind;
            end
            if (hs) begin
                pend      <= 1'b0;
                buf_bytes <= '0;
                buf_data  <= '0;
                excl_done <= pend_kind[1];
                if (pend_kind[1]) begin
                    excl_pass <= mem_ok;
                end
            end
        end
    end

    // Write port driven from the held entry
    always_comb begin
        mem_valid = pend;
        mem_addr  = buf_addr;
        mem_bytes = buf_bytes;
        mem_data  = buf_data;
        mem_kind  = pend_kind;
    end
endmodule

// File: rtl/smb_checker.sv
// Property checker for store_merge_buf, attached by bind.
// Assumes occ is the held byte count inside the top module.
module smb_checker #(
    parameter int NBYTES = 16,
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [CNT_W-1:0]    mem_bytes,
    input logic [NBYTES*8-1:0] mem_data,
    input logic [1:0]          mem_kind,
    input logic                excl_done,
    input logic                err,
    input logic [CNT_W-1:0]    occ
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NBYTES);

    AST_DATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_data >> {mem_bytes, 3'b000}) == '0)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= MAX_CNT); // R6
    AST_POW2_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_bytes) == 1 && mem_bytes <= MAX_CNT)); // R7
    AST_EXCL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        excl_done |-> $past(mem_valid && mem_ready && mem_kind[1])); // R9
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)
            && $stable(mem_bytes) && $stable(mem_kind)); // R10
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid && occ == '0); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R11
endmodule

bind store_merge_buf smb_checker #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_smb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_bytes(mem_bytes),
    .mem_data (mem_data),
    .mem_kind (mem_kind),
    .excl_done(excl_done),
    .err      (err),
    .occ      (buf_bytes)
);

// File: tb/store_merge_buf_bench.sv
// Directed bench for store_merge_buf: one task per scenario.
module store_merge_buf_bench;
    localparam int ADDR_W = 64;
    localparam int NBYTES = 16;
    localparam int CNT_W  = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                st_valid = 1'b0;
    logic [ADDR_W-1:0]   st_addr = '0;
    logic [NBYTES*8-1:0] st_data = '0;
    logic [CNT_W-1:0]    st_bytes = '0;
    logic [2:0]          st_acc = '0;
    logic                st_excl = 1'b0;
    logic                flush_req = 1'b0;
    logic                flush_excl = 1'b0;
    logic                mem_valid;
    logic                mem_ready = 1'b0;
    logic [ADDR_W-1:0]   mem_addr;
    logic [CNT_W-1:0]    mem_bytes;
    logic [NBYTES*8-1:0] mem_data;
    logic [1:0]          mem_kind;
    logic                mem_ok = 1'b0;
    logic                excl_done;
    logic                excl_pass;
    logic                err;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    store_merge_buf #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_store_merge_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_bytes(st_bytes), .st_acc(st_acc), .st_excl(st_excl),
        .flush_req(flush_req), .flush_excl(flush_excl),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_data(mem_data), .mem_kind(mem_kind),
        .mem_ok(mem_ok), .excl_done(excl_done), .excl_pass(excl_pass), .err(err)
    );

    task automatic check(input bit cond, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!cond) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_store(input logic [63:0] a, input logic [127:0] d,
                            input int nb, input logic [2:0] acc, input bit ex);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        st_bytes = CNT_W'(nb); st_acc = acc; st_excl = ex;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // Flush expected to issue a write; checks fields, hold and completion
    task automatic flush_ok(input bit ex, input logic [63:0] a, input int nb,
                            input logic [127:0] d, input logic [1:0] k,
                            input int delay, input bit ok, input string req);
        @(negedge clk);
        flush_req = 1'b1; flush_excl = ex;
        @(negedge clk);
        flush_req = 1'b0;
        check(mem_valid == 1'b1, req, 128'(mem_valid), 128'd1);
        check(mem_addr == a, req, 128'(mem_addr), 128'(a));
        check(mem_bytes == CNT_W'(nb), req, 128'(mem_bytes), 128'(nb));
        check(mem_data == d, req, mem_data, d);
        check(mem_kind == k, req, 128'(mem_kind), 128'(k));
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            check(mem_valid && mem_data == d && mem_kind == k, "R10 hold",
                  mem_data, d);
        end
        mem_ready = 1'b1; mem_ok = ok;
        @(negedge clk);
        mem_ready = 1'b0; mem_ok = 1'b0;
        check(mem_valid == 1'b0, "R10 idle after handshake", 128'(mem_valid), 128'd0);
        check(excl_done == ex, "R9 done pulse", 128'(excl_done), 128'(ex));
        if (ex) check(excl_pass == ok, "R9 pass bit", 128'(excl_pass), 128'(ok));
        @(negedge clk);
        check(excl_done == 1'b0, "R9 pulse ends", 128'(excl_done), 128'd0);
    endtask

    // Flush expected to be refused
    task automatic flush_bad(input bit ex, input string req);
        @(negedge clk);
        flush_req = 1'b1; flush_excl = ex;
        @(negedge clk);
        flush_req = 1'b0;
        check(mem_valid == 1'b0, req, 128'(mem_valid), 128'd0);
        check(err == 1'b1, req, 128'(err), 128'd1);
    endtask

    task automatic t_reset();
        do_reset();
        check(mem_valid == 1'b0, "R1 valid", 128'(mem_valid), 128'd0);
        check(err == 1'b0, "R1 err", 128'(err), 128'd0);
        check(excl_done == 1'b0, "R1 done", 128'(excl_done), 128'd0);
        flush_bad(1'b0, "R1 empty after reset / R7 size 0");
    endtask

    task automatic t_load();
        do_reset();
        do_store(64'h1000, 128'hFFFF_FFFF_ABCD, 2, 3'd0, 1'b0);
        flush_ok(1'b0, 64'h1000, 2, 128'hABCD, 2'd0, 0, 1'b0, "R2 load");
        check(err == 1'b0, "R2 no err", 128'(err), 128'd0);
    endtask

    task automatic t_merge8();
        do_reset();
        do_store(64'h2000, 128'hDEAD_BEEF_1122_3344, 4, 3'd3, 1'b0);
        do_store(64'h2004, 128'h5566_7788, 4, 3'd3, 1'b0);
        flush_ok(1'b0, 64'h2000, 8, 128'h5566778811223344, 2'd1, 3, 1'b0,
                 "R3 merge / R8 ordered");
    endtask

    task automatic t_merge16();
        do_reset();
        do_store(64'h3000, 128'h8877665544332211, 8, 3'd1, 1'b0);
        do_store(64'h3008, 128'hDDCCBBAA, 4, 3'd1, 1'b0);
        do_store(64'h300C, 128'h1234_FFEE, 2, 3'd1, 1'b0);
        do_store(64'h300E, 128'hFFFF_FF5A, 1, 3'd1, 1'b0);
        do_store(64'h300F, 128'hA5, 1, 3'd1, 1'b0);
        flush_ok(1'b0, 64'h3000, 16, 128'hA55AFFEEDDCCBBAA8877665544332211,
                 2'd0, 1, 1'b0, "R3 full merge / R2 masking");
        do_store(64'h3100, 128'h77, 1, 3'd2, 1'b0);
        flush_ok(1'b0, 64'h3100, 1, 128'h77, 2'd0, 0, 1'b0, "R8 unpriv");
    endtask

    task automatic t_excl();
        do_reset();
        do_store(64'h4000, 128'h0102030405060708, 8, 3'd4, 1'b1);
        flush_ok(1'b1, 64'h4000, 8, 128'h0102030405060708, 2'd2, 0, 1'b1, "R9 atomic");
        do_store(64'h4100, 128'hBEEF, 2, 3'd3, 1'b1);
        flush_ok(1'b1, 64'h4100, 2, 128'hBEEF, 2'd3, 2, 1'b0, "R9 atomic-ordered");
        check(err == 1'b0, "R9 no err", 128'(err), 128'd0);
    endtask

    task automatic t_mismatch();
        do_reset();
        do_store(64'h5000, 128'hCAFEF00D, 4, 3'd0, 1'b0);
        do_store(64'h5004, 128'h11111111, 4, 3'd3, 1'b0);
        check(err == 1'b1, "R4 tag mismatch", 128'(err), 128'd1);
        do_store(64'h5004, 128'h22222222, 4, 3'd0, 1'b1);
        flush_ok(1'b0, 64'h5000, 4, 128'hCAFEF00D, 2'd0, 0, 1'b0, "R4 unchanged");
    endtask

    task automatic t_gap();
        do_reset();
        do_store(64'h6000, 128'h44332211, 4, 3'd0, 1'b0);
        do_store(64'h6008, 128'h99999999, 4, 3'd0, 1'b0);
        check(err == 1'b1, "R5 gap", 128'(err), 128'd1);
        flush_ok(1'b0, 64'h6000, 4, 128'h44332211, 2'd0, 0, 1'b0, "R5 unchanged");
    endtask

    task automatic t_overflow();
        do_reset();
        do_store(64'h7000, 128'h0, 0, 3'd0, 1'b0);
        check(err == 1'b1, "R6 zero size", 128'(err), 128'd1);
        do_store(64'h7000, 128'h1, 17, 3'd0, 1'b0);
        flush_bad(1'b0, "R6 size 17 not loaded");
        do_store(64'h7000, 128'hAAAABBBBCCCCDDDD, 8, 3'd0, 1'b0);
        do_store(64'h7008, {128{1'b1}}, 16, 3'd0, 1'b0);
        flush_ok(1'b0, 64'h7000, 8, 128'hAAAABBBBCCCCDDDD, 2'd0, 0, 1'b0,
                 "R6 overflow unchanged");
    endtask

    task automatic t_badsize();
        do_reset();
        do_store(64'h8000, 128'h11, 1, 3'd0, 1'b0);
        do_store(64'h8001, 128'h2233, 2, 3'd0, 1'b0);
        flush_bad(1'b0, "R7 size 3");
        do_store(64'h8003, 128'h44, 1, 3'd0, 1'b0);
        flush_ok(1'b0, 64'h8000, 4, 128'h44223311, 2'd0, 0, 1'b0, "R7 kept");
        check(err == 1'b1, "R11 sticky", 128'(err), 128'd1);
    endtask

    task automatic t_path();
        do_reset();
        do_store(64'h9000, 128'h12345678, 4, 3'd4, 1'b0);
        flush_bad(1'b0, "R8 atomic tag on plain path");
        do_reset();
        do_store(64'h9100, 128'h6, 1, 3'd6, 1'b0);
        flush_bad(1'b0, "R8 tag 6");
        do_reset();
        do_store(64'h9200, 128'h9ABC, 2, 3'd0, 1'b0);
        flush_bad(1'b1, "R9 exclusive path with flag clear");
        flush_ok(1'b0, 64'h9200, 2, 128'h9ABC, 2'd0, 0, 1'b0, "R8 after refusal");
        do_reset();
        do_store(64'h9300, 128'h5A, 1, 3'd4, 1'b1);
        flush_bad(1'b0, "R8 plain path with flag set");
    endtask

    task automatic t_busy();
        do_reset();
        do_store(64'hA000, 128'h0F0E0D0C, 4, 3'd0, 1'b0);
        @(negedge clk);
        st_valid = 1'b1; flush_req = 1'b1; flush_excl = 1'b0;
        st_addr = 64'hA004; st_data = 128'h1; st_bytes = 5'd4; st_acc = 3'd0; st_excl = 1'b0;
        @(negedge clk);
        st_valid = 1'b0; flush_req = 1'b0;
        check(mem_valid == 1'b0 && err == 1'b1, "R12 same cycle", 128'(mem_valid), 128'd0);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        check(mem_valid == 1'b1, "R12 flush issued", 128'(mem_valid), 128'd1);
        do_store(64'hA004, 128'h99999999, 4, 3'd0, 1'b0);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        check(mem_data == 128'h0F0E0D0C && mem_bytes == 5'd4, "R12 busy ignored",
              mem_data, 128'h0F0E0D0C);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        check(mem_valid == 1'b0, "R10 drained", 128'(mem_valid), 128'd0);
        flush_bad(1'b0, "R10 empty after handshake");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_merge8();
        t_merge16();
        t_excl();
        t_mismatch();
        t_gap();
        t_overflow();
        t_badsize();
        t_path();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule